// File: doc/BRIEF.md
# Outbound Transaction Ordering Queue

This block sits on the downstream side of a single PCI Express style port and decides which waiting transaction goes to the link next. Each incoming transaction carries a two-bit class code and an opaque tag. The class is posted (memory writes and messages), non-posted (reads, I/O and configuration requests) or completion. The block files each transaction into a small FIFO for its class. Every accepted transaction also gets an arrival sequence number, so that age can be compared across the three FIFOs.

On every cycle the link side supplies one ready bit per class, which models flow-control blocking. From the three FIFO heads the block chooses the oldest head that is allowed to go. A posted write may overtake a stalled read or completion. A completion may overtake a stalled read. No read or completion may leave ahead of an older posted transaction that is still queued. Within each class, order is strictly first in, first out. One port is served per instance, and separate ports use separate instances.

Top module: `txn_order_queue`

## Requirements
- R1: The class code is 2'b00 for posted, 2'b01 for non-posted and 2'b10 for completion. A transaction offered with code 2'b11 is dropped: it is not stored and never appears at the output.
- R2: Each class holds at most DEPTH (default 4) entries. Bit 0, 1 or 2 of `in_full` (posted, non-posted, completion) is high while that class holds DEPTH entries. A transaction offered to a full class is dropped. The bit returns low once the class drains.
- R3: Posted transactions leave in arrival order. A posted head whose ready bit (`link_rdy` bit 0) is high is never held back by a stalled non-posted or completion entry.
- R4: A non-posted or completion entry is never issued while an older posted entry is still queued.
- R5: A completion whose ready bit (`link_rdy` bit 2) is high, and which has no older posted entry queued, is issued even while an older non-posted request is stalled (`link_rdy` bit 1 low).
- R6: Completions leave in arrival order, so partial completions keep the ascending address order in which the producer supplies them.
- R7: Non-posted requests leave in arrival order.
- R8: When several heads are allowed to go, the one with the oldest sequence number wins. The comparison stays correct after the SEQ_W-bit counter wraps.
- R9: At most one transaction is issued per cycle. `out_valid`, `out_class` and `out_tag` are registered. They show the choice made from the ready bits and queue contents of the previous cycle, and `out_valid` is low in a cycle after which nothing could go.
- R10: After synchronous reset all queues are empty, `out_valid` is low and `in_full` is 3'b000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Offer a transaction this cycle |
| in_class | input | 2 | Class code of the offered transaction |
| in_tag | input | TAG_W | Opaque tag of the offered transaction |
| in_full | output | 3 | Per-class full flags (back-pressure) |
| link_rdy | input | 3 | Per-class link ready bits, indexed by class code |
| out_valid | output | 1 | A transaction is being issued |
| out_class | output | 2 | Class code of the issued transaction |
| out_tag | output | TAG_W | Tag of the issued transaction |

## Verification
The age checks assume that a live entry never waits while 2^(SEQ_W-1) or more later transactions are accepted. Below that limit the wrapped difference of two sequence numbers orders them correctly. The stimulus keeps every live span below about a dozen entries. It still accepts enough traffic to wrap the counter several times, and rotates the class order inside each batch so that the wrap point falls between different pairs of classes. The bench also assumes that producers only offer code 2'b11 as a deliberate error case and never rely on it being stored.

// File: rtl/oq_pkg.sv
package oq_pkg;
  localparam int NCLS = 3;

  typedef enum logic [1:0] {
    CLS_POST = 2'd0,
    CLS_NONP = 2'd1,
    CLS_CMPL = 2'd2
  } oq_cls_e;
endpackage

// File: rtl/oq_class_fifo.sv
module oq_class_fifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  // storage has no reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign head  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
endmodule

// File: rtl/oq_pick.sv
module oq_pick #(
  parameter int SEQ_W = 5
) (
  input  logic [oq_pkg::NCLS-1:0]            vld,
  input  logic [oq_pkg::NCLS-1:0]            rdy,
  input  logic [oq_pkg::NCLS-1:0][SEQ_W-1:0] seq,
  output logic [oq_pkg::NCLS-1:0]            grant
);
  import oq_pkg::*;

  localparam int P = int'(CLS_POST);
  localparam int N = int'(CLS_NONP);
  localparam int C = int'(CLS_CMPL);

  logic [NCLS-1:0] elig;
  logic [SEQ_W-1:0] best;
  logic             found;

  // a is older than b when the wrapped difference is negative
  function automatic logic older(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return d[SEQ_W-1];
  endfunction

  // fixed scan order for the tie-break: posted, completion, non-posted
  function automatic int scan_idx(input int k);
    case (k)
      0:       return P;
      1:       return C;
      default: return N;
    endcase
  endfunction

  always_comb begin
    elig[P] = vld[P] && rdy[P];
    elig[N] = vld[N] && rdy[N] && !(vld[P] && older(seq[P], seq[N]));
    elig[C] = vld[C] && rdy[C] && !(vld[P] && older(seq[P], seq[C]));

    grant = '0;
    best  = '0;
    found = 1'b0;
    for (int k = 0; k < NCLS; k++) begin
      if (elig[scan_idx(k)] && (!found || older(seq[scan_idx(k)], best))) begin
        grant                = '0;
        grant[scan_idx(k)]   = 1'b1;
        best                 = seq[scan_idx(k)];
        found                = 1'b1;
      end
    end
  end
endmodule

// File: rtl/oq_out_reg.sv
module oq_out_reg #(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [1:0]       cls,
  input  logic [TAG_W-1:0] tag,
  output logic             out_valid,
  output logic [1:0]       out_class,
  output logic [TAG_W-1:0] out_tag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_class <= '0;
      out_tag   <= '0;
    end else begin
      out_valid <= fire;
      if (fire) begin
        out_class <= cls;
        out_tag   <= tag;
      end
    end
  end
endmodule

// File: rtl/txn_order_queue.sv
module txn_order_queue #(
  parameter int TAG_W = 8,
  parameter int DEPTH = 4,
  parameter int SEQ_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       in_class,
  input  logic [TAG_W-1:0] in_tag,
  output logic [2:0]       in_full,
  input  logic [2:0]       link_rdy,
  output logic             out_valid,
  output logic [1:0]       out_class,
  output logic [TAG_W-1:0] out_tag
);
  import oq_pkg::*;

  localparam int ENT_W = SEQ_W + TAG_W;

  logic [SEQ_W-1:0]                 seq_ctr;
  logic [NCLS-1:0]                  push_vec;
  logic [NCLS-1:0]                  head_vld;
  logic [NCLS-1:0]                  grant;
  logic [NCLS-1:0][SEQ_W-1:0]       head_seq;
  logic [NCLS-1:0][TAG_W-1:0]       head_tag;
  logic                             accept;
  logic [1:0]                       sel_cls;
  logic [TAG_W-1:0]                 sel_tag;

  for (genvar g = 0; g < NCLS; g++) begin : g_cls
    logic [ENT_W-1:0] head_ent;
    logic             empty;

    assign push_vec[g] = in_valid && (in_class == 2'(g)) && !in_full[g];

    oq_class_fifo #(.DEPTH(DEPTH), .DW(ENT_W)) u_fifo (
      .clk   (clk),
      .rst   (rst),
      .push  (push_vec[g]),
      .wdata ({seq_ctr, in_tag}),
      .pop   (grant[g]),
      .head  (head_ent),
      .empty (empty),
      .full  (in_full[g])
    );

    assign head_vld[g] = !empty;
    assign head_seq[g] = head_ent[ENT_W-1:TAG_W];
    assign head_tag[g] = head_ent[TAG_W-1:0];
  end

  assign accept = |push_vec;

  always_ff @(posedge clk) begin
    if (rst)         seq_ctr <= '0;
    else if (accept) seq_ctr <= seq_ctr + 1'b1;
  end

  oq_pick #(.SEQ_W(SEQ_W)) u_pick (
    .vld   (head_vld),
    .rdy   (link_rdy),
    .seq   (head_seq),
    .grant (grant)
  );

  always_comb begin
    sel_cls = '0;
    sel_tag = '0;
    for (int k = 0; k < NCLS; k++) begin
      if (grant[k]) begin
        sel_cls = 2'(k);
        sel_tag = head_tag[k];
      end
    end
  end

  oq_out_reg #(.TAG_W(TAG_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .fire      (|grant),
    .cls       (sel_cls),
    .tag       (sel_tag),
    .out_valid (out_valid),
    .out_class (out_class),
    .out_tag   (out_tag)
  );
endmodule

// File: rtl/oq_checker.sv
module oq_checker #(
  parameter int SEQ_W = 5
) (
  input logic                  clk,
  input logic                  rst,
  input logic [2:0]            grant,
  input logic [2:0]            head_vld,
  input logic [2:0][SEQ_W-1:0] head_seq,
  input logic [2:0]            link_rdy,
  input logic [2:0]            in_full,
  input logic                  out_valid
);
  logic [SEQ_W-1:0] d_pn, d_pc;
  logic             post_before_np, post_before_cpl;

  assign d_pn            = head_seq[0] - head_seq[1];
  assign d_pc            = head_seq[0] - head_seq[2];
  assign post_before_np  = head_vld[0] && d_pn[SEQ_W-1];
  assign post_before_cpl = head_vld[0] && d_pc[SEQ_W-1];

  a_r9_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  a_r4_np_waits_posted: assert property (@(posedge clk) disable iff (rst)
    grant[1] |-> !post_before_np);

  a_r4_cpl_waits_posted: assert property (@(posedge clk) disable iff (rst)
    grant[2] |-> !post_before_cpl);

  a_r3_posted_progress: assert property (@(posedge clk) disable iff (rst)
    (head_vld[0] && link_rdy[0]) |-> (grant != 3'b000));

  a_r5_cpl_passes_np: assert property (@(posedge clk) disable iff (rst)
    (head_vld[2] && link_rdy[2] && !link_rdy[1] && !post_before_cpl) |-> (grant != 3'b000));

  a_r9_out_follows_grant: assert property (@(posedge clk) disable iff (rst)
    (grant != 3'b000) |=> out_valid);

  a_r9_out_idle: assert property (@(posedge clk) disable iff (rst)
    (grant == 3'b000) |=> !out_valid);

  a_r2_full_holds: assert property (@(posedge clk) disable iff (rst)
    (in_full[0] && !grant[0]) |=> in_full[0]);

  a_r10_reset_state: assert property (@(posedge clk)
    rst |=> (!out_valid && in_full == 3'b000));
endmodule

bind txn_order_queue oq_checker #(.SEQ_W(SEQ_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .grant     (grant),
  .head_vld  (head_vld),
  .head_seq  (head_seq),
  .link_rdy  (link_rdy),
  .in_full   (in_full),
  .out_valid (out_valid)
);

// File: tb/sim_txn_order_queue.sv
module sim_txn_order_queue;
  localparam int TAG_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [1:0]       in_class = 2'b00;
  logic [TAG_W-1:0] in_tag = '0;
  logic [2:0]       in_full;
  logic [2:0]       link_rdy = 3'b000;
  logic             out_valid;
  logic [1:0]       out_class;
  logic [TAG_W-1:0] out_tag;

  int total = 0;
  int bad   = 0;
  string cur_req = "R10";
  logic [TAG_W+1:0] exp_q[$];

  always #5 clk = ~clk;

  txn_order_queue #(.TAG_W(TAG_W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class),
    .in_tag(in_tag), .in_full(in_full), .link_rdy(link_rdy),
    .out_valid(out_valid), .out_class(out_class), .out_tag(out_tag)
  );

  task automatic check(input logic ok, input string rq, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, expv);
    end
  endtask

  task automatic push(input logic [1:0] cls, input logic [TAG_W-1:0] tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_class = cls;
    in_tag   = tag;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_item(input logic [1:0] cls, input logic [TAG_W-1:0] tag);
    exp_q.push_back({cls, tag});
  endtask

  task automatic set_rdy(input logic [2:0] v);
    @(negedge clk);
    link_rdy = v;
  endtask

  task automatic drain(input int n, input string rq);
    repeat (n) @(negedge clk);
    check(exp_q.size() == 0, rq, exp_q.size(), 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL %s actual=%0d:%0d expected=none", cur_req, out_class, out_tag);
      end else begin
        logic [TAG_W+1:0] e;
        e = exp_q.pop_front();
        if ({out_class, out_tag} !== e) begin
          bad++;
          $display("FAIL %s actual=%0d:%0d expected=%0d:%0d", cur_req,
                   out_class, out_tag, e[TAG_W+1:TAG_W], e[TAG_W-1:0]);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check(out_valid == 1'b0, "R10", out_valid, 0);
    check(in_full == 3'b000, "R10", in_full, 0);

    // R8: all ready, mixed classes -> arrival order
    cur_req = "R8";
    push(2'd0, 8'd1); push(2'd1, 8'd2); push(2'd2, 8'd3); push(2'd0, 8'd4); push(2'd2, 8'd5);
    expect_item(2'd0, 8'd1); expect_item(2'd1, 8'd2); expect_item(2'd2, 8'd3);
    expect_item(2'd0, 8'd4); expect_item(2'd2, 8'd5);
    set_rdy(3'b111);
    drain(10, "R8");
    set_rdy(3'b000);

    // R5 and R3: non-posted stalled, completion and posted go around it
    cur_req = "R5";
    push(2'd1, 8'd10); push(2'd2, 8'd11); push(2'd0, 8'd12);
    expect_item(2'd2, 8'd11); expect_item(2'd0, 8'd12);
    set_rdy(3'b101);
    drain(6, "R5");
    cur_req = "R3";
    expect_item(2'd1, 8'd10);
    set_rdy(3'b111);
    drain(4, "R3");
    set_rdy(3'b000);

    // R4: older posted stalled blocks completion and non-posted
    cur_req = "R4";
    push(2'd0, 8'd20); push(2'd2, 8'd21); push(2'd1, 8'd22);
    expect_item(2'd0, 8'd20); expect_item(2'd2, 8'd21); expect_item(2'd1, 8'd22);
    set_rdy(3'b110);
    repeat (6) @(negedge clk);
    check(exp_q.size() == 3, "R4", exp_q.size(), 3);
    set_rdy(3'b111);
    drain(6, "R4");
    set_rdy(3'b000);

    // R2: fill the posted class, fifth offer dropped
    cur_req = "R2";
    for (int i = 0; i < 4; i++) push(2'd0, 8'(30 + i));
    check(in_full == 3'b001, "R2", in_full, 1);
    push(2'd0, 8'd34);
    check(in_full == 3'b001, "R2", in_full, 1);
    for (int i = 0; i < 4; i++) expect_item(2'd0, 8'(30 + i));
    set_rdy(3'b001);
    drain(8, "R2");
    check(in_full == 3'b000, "R2", in_full, 0);
    set_rdy(3'b000);

    // R1: code 2'b11 dropped
    cur_req = "R1";
    push(2'd3, 8'd40); push(2'd2, 8'd41);
    expect_item(2'd2, 8'd41);
    set_rdy(3'b111);
    drain(6, "R1");
    check(in_full == 3'b000, "R1", in_full, 0);
    set_rdy(3'b000);

    // R6: completions keep order; younger ones wait behind stalled posted
    cur_req = "R6";
    push(2'd2, 8'd50); push(2'd0, 8'd53); push(2'd2, 8'd51); push(2'd2, 8'd52);
    expect_item(2'd2, 8'd50);
    set_rdy(3'b100);
    drain(6, "R6");
    expect_item(2'd0, 8'd53); expect_item(2'd2, 8'd51); expect_item(2'd2, 8'd52);
    set_rdy(3'b111);
    drain(6, "R6");
    set_rdy(3'b000);

    // R7 and R9: non-posted in order, output one cycle after release
    cur_req = "R7";
    push(2'd1, 8'd60); push(2'd1, 8'd61); push(2'd1, 8'd62);
    expect_item(2'd1, 8'd60); expect_item(2'd1, 8'd61); expect_item(2'd1, 8'd62);
    set_rdy(3'b111);
    check(out_valid == 1'b0, "R9", out_valid, 0);
    @(negedge clk);
    check(out_valid == 1'b1 && out_tag == 8'd60, "R9", out_tag, 60);
    drain(4, "R7");
    check(out_valid == 1'b0, "R9", out_valid, 0);
    set_rdy(3'b000);

    // R8: sequence wrap, rotating class order inside each batch
    cur_req = "R8";
    for (int b = 0; b < 32; b++) begin
      for (int j = 0; j < 3; j++) begin
        logic [1:0] c;
        c = 2'((b + j) % 3);
        push(c, 8'(100 + 3 * (b % 40) + j));
        expect_item(c, 8'(100 + 3 * (b % 40) + j));
      end
      set_rdy(3'b111);
      repeat (4) @(negedge clk);
      link_rdy = 3'b000;
    end
    drain(4, "R8");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule